// File: doc/BRIEF.md
# Remapping Unit Global Command and Status

This block sits in front of the back-end engines of a DMA and interrupt remapping unit. Software writes a 32-bit command word and reads a 32-bit status word. Each meaningful command bit starts a request/acknowledge handshake with one engine. The status bits report the progress or the result of that handshake. Two commands load a table pointer: one for the root table and one for the interrupt remap table. For these, the block takes a snapshot of the address register when the command arrives and offers it to the engine. The snapshot becomes the live pointer when the engine acknowledges.

The command word is write-only and carries the complete wanted state of the level controls on every write: translation enable, interrupt remap enable, queued invalidation enable and compatibility bypass. A level handshake starts only when the written value differs from the current enabled state. One-shot operations have their own behaviour: a pointer load clears its ready bit until the engine acknowledges, while a write-buffer flush raises its busy bit until the engine acknowledges. Capability straps gate the optional features. A command for a missing feature is dropped, and its status bit reads 0.

Top module: `remap_gcmd_unit`

## Requirements
- R1: After reset the status word reads 0, no request output is high, all enable outputs are 0 and both live pointers are 0.
- R2: A write with bit 30 set lowers status bit 30 (root pointer ready) from the next cycle. It raises `rtpReq` and offers the `rootAddrIn` value seen at the write on `reqRootPtr`. On `rtpAck`, `rtpReq` drops, `rootPtr` takes the offered value and status bit 30 reads 1.
- R3: A write with bit 24 set does the same for the interrupt remap table. It uses `irtAddrIn`, `irtpReq`/`irtpAck`, `reqIrtPtr`, `irtPtr` and status bit 24. It acts only when `capIntr` is 1.
- R4: A write with bit 27 set, when `capFlush` is 1, sets status bit 27 and `wbfReq`. Both return to 0 on `wbfAck`.
- R5: Bit 31 of each write is the wanted translation state. If it differs from status bit 31, `teReq` rises with `teTarget` equal to it. Status bit 31 and `dmaRemapEn` take the new value only on `teAck`.
- R6: Bit 25 (interrupt remap, needs `capIntr`) and bit 26 (queued invalidation, needs `capQinv`) behave like bit 31, through `ireReq`/`ireAck` and `qieReq`/`qieAck`. Their state is reported on status bits 25 and 26 and on `intRemapEn` and `qInvEn`.
- R7: A level bit written with the value it already has starts no request.
- R8: While a root pointer load, interrupt table pointer load or flush is pending, a repeat of that command is ignored, and the offered pointer stays unchanged.
- R9: A command whose capability strap is 0 starts no request, and its status bit reads 0.
- R10: Every write with `capIntr` = 1 stores bit 23 as the compatibility bypass choice. Status bit 23 and `compatBypass` show that choice only while interrupt remapping is enabled and `extIntMode` is 0; otherwise they read 0.
- R11: Command bits 0 to 22, 28 and 29 have no effect, and the same bits of the status word read 0.
- R12: An acknowledge that arrives while its request is not pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrEn | input | 1 | Command write strobe |
| cmdWrData | input | 32 | Command word |
| statusRdData | output | 32 | Status word |
| capFlush | input | 1 | Strap: write-buffer flush required |
| capIntr | input | 1 | Strap: interrupt remapping present |
| capQinv | input | 1 | Strap: queued invalidation present |
| extIntMode | input | 1 | Extended interrupt mode is active |
| rootAddrIn | input | PTR_W | Root table address register value |
| irtAddrIn | input | PTR_W | Interrupt remap table address register value |
| rtpReq | output | 1 | Root pointer load request |
| rtpAck | input | 1 | Root pointer load done |
| reqRootPtr | output | PTR_W | Root pointer offered to the engine |
| irtpReq | output | 1 | Interrupt table pointer load request |
| irtpAck | input | 1 | Interrupt table pointer load done |
| reqIrtPtr | output | PTR_W | Interrupt table pointer offered to the engine |
| wbfReq | output | 1 | Write-buffer flush request |
| wbfAck | input | 1 | Flush done |
| teReq | output | 1 | Translation enable change request |
| teTarget | output | 1 | Wanted translation state |
| teAck | input | 1 | Translation change done |
| ireReq | output | 1 | Interrupt remap enable change request |
| ireTarget | output | 1 | Wanted interrupt remap state |
| ireAck | input | 1 | Interrupt remap change done |
| qieReq | output | 1 | Queued invalidation enable change request |
| qieTarget | output | 1 | Wanted queued invalidation state |
| qieAck | input | 1 | Queued invalidation change done |
| dmaRemapEn | output | 1 | DMA translation is enabled |
| intRemapEn | output | 1 | Interrupt remapping is enabled |
| qInvEn | output | 1 | Queued invalidation is enabled |
| compatBypass | output | 1 | Compatibility-format interrupts bypass remapping |
| rootPtr | output | PTR_W | Live root table pointer |
| irtPtr | output | PTR_W | Live interrupt remap table pointer |

## Verification
The bench builds the block with `PTR_W` = 12. This keeps the pointer values short enough to tell them apart at a glance. It repeats one command sequence for all eight settings of the three capability straps, so every gated command is seen both with and without its feature. Each pass also covers the corner cases: repeated commands while one is pending, stray acknowledges, unused bits, and toggling extended interrupt mode. A small bench-side status model gives the expected word after every step.

// File: rtl/remap_gcmd_pkg.sv
package remap_gcmd_pkg;
  localparam int REG_W = 32;

  // Command and status bit positions (shared by software and hardware)
  localparam int POS_COMPAT = 23;
  localparam int POS_IRT    = 24;
  localparam int POS_INTR   = 25;
  localparam int POS_QINV   = 26;
  localparam int POS_FLUSH  = 27;
  localparam int POS_ROOT   = 30;
  localparam int POS_XLATE  = 31;

  // Level channel indices
  localparam int NUM_LVL  = 3;
  localparam int LV_XLATE = 0;
  localparam int LV_INTR  = 1;
  localparam int LV_QINV  = 2;

  // One-shot channel indices; pointer channels come first
  localparam int NUM_OP   = 3;
  localparam int NUM_PTR  = 2;
  localparam int OP_ROOT  = 0;
  localparam int OP_IRT   = 1;
  localparam int OP_FLUSH = 2;

  typedef struct packed {
    logic [NUM_LVL-1:0] lvlStart;
    logic [NUM_PTR-1:0] ptrStart;
    logic [NUM_PTR-1:0] ptrDone;
    logic               compatLoad;
  } strobe_t;
endpackage

// File: rtl/remap_gcmd_ctrl.sv
module remap_gcmd_ctrl
  import remap_gcmd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrEn,
  input  logic [NUM_LVL-1:0] cmdLvl,
  input  logic [NUM_OP-1:0]  cmdOp,
  input  logic [NUM_LVL-1:0] lvlCap,
  input  logic [NUM_OP-1:0]  opCap,
  input  logic               compatCap,
  input  logic [NUM_LVL-1:0] lvlTarget,
  input  logic [NUM_LVL-1:0] lvlAck,
  input  logic [NUM_OP-1:0]  opAck,
  output strobe_t            stb,
  output logic [NUM_LVL-1:0] lvlPend,
  output logic [NUM_LVL-1:0] lvlState,
  output logic [NUM_OP-1:0]  opPend,
  output logic [NUM_PTR-1:0] ptrReady
);
  logic [NUM_LVL-1:0] lvlStartV;
  logic [NUM_LVL-1:0] lvlDoneV;
  logic [NUM_OP-1:0]  opStartV;
  logic [NUM_OP-1:0]  opDoneV;

  // Level channels: a request starts only on a change of wanted state
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign lvlStartV[g] = cmdWrEn & lvlCap[g] & ~lvlPend[g] & (cmdLvl[g] ^ lvlState[g]);
    assign lvlDoneV[g]  = lvlPend[g] & lvlAck[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lvlPend[g]  <= 1'b0;
        lvlState[g] <= 1'b0;
      end else if (lvlStartV[g]) begin
        lvlPend[g] <= 1'b1;
      end else if (lvlDoneV[g]) begin
        lvlPend[g]  <= 1'b0;
        lvlState[g] <= lvlTarget[g];
      end
    end
  end

  // One-shot channels: a set command bit starts, a repeat while busy is dropped
  for (genvar g = 0; g < NUM_OP; g++) begin : g_op
    assign opStartV[g] = cmdWrEn & opCap[g] & cmdOp[g] & ~opPend[g];
    assign opDoneV[g]  = opPend[g] & opAck[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            opPend[g] <= 1'b0;
      else if (opStartV[g]) opPend[g] <= 1'b1;
      else if (opDoneV[g])  opPend[g] <= 1'b0;
    end
  end

  // Pointer channels report ready with the opposite sense to busy
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_rdy
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            ptrReady[g] <= 1'b0;
      else if (opStartV[g]) ptrReady[g] <= 1'b0;
      else if (opDoneV[g])  ptrReady[g] <= 1'b1;
    end
  end

  assign stb.lvlStart   = lvlStartV;
  assign stb.ptrStart   = opStartV[NUM_PTR-1:0];
  assign stb.ptrDone    = opDoneV[NUM_PTR-1:0];
  assign stb.compatLoad = cmdWrEn & compatCap;
endmodule

// File: rtl/remap_gcmd_dp.sv
module remap_gcmd_dp
  import remap_gcmd_pkg::*;
#(
  parameter int PTR_W = 52
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        stb,
  input  logic [NUM_LVL-1:0]             cmdLvl,
  input  logic                           cmdCompat,
  input  logic [NUM_PTR-1:0][PTR_W-1:0]  ptrIn,
  output logic [NUM_LVL-1:0]             lvlTarget,
  output logic                           compatSel,
  output logic [NUM_PTR-1:0][PTR_W-1:0]  ptrPend,
  output logic [NUM_PTR-1:0][PTR_W-1:0]  ptrLive
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_tgt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                lvlTarget[g] <= 1'b0;
      else if (stb.lvlStart[g]) lvlTarget[g] <= cmdLvl[g];
    end
  end

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrPend[g] <= '0;
        ptrLive[g] <= '0;
      end else begin
        if (stb.ptrStart[g]) ptrPend[g] <= ptrIn[g];
        if (stb.ptrDone[g])  ptrLive[g] <= ptrPend[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               compatSel <= 1'b0;
    else if (stb.compatLoad) compatSel <= cmdCompat;
  end
endmodule

// File: rtl/remap_gcmd_unit.sv
module remap_gcmd_unit
  import remap_gcmd_pkg::*;
#(
  parameter int PTR_W = 52
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [REG_W-1:0]  cmdWrData,
  output logic [REG_W-1:0]  statusRdData,
  input  logic              capFlush,
  input  logic              capIntr,
  input  logic              capQinv,
  input  logic              extIntMode,
  input  logic [PTR_W-1:0]  rootAddrIn,
  input  logic [PTR_W-1:0]  irtAddrIn,
  output logic              rtpReq,
  input  logic              rtpAck,
  output logic [PTR_W-1:0]  reqRootPtr,
  output logic              irtpReq,
  input  logic              irtpAck,
  output logic [PTR_W-1:0]  reqIrtPtr,
  output logic              wbfReq,
  input  logic              wbfAck,
  output logic              teReq,
  output logic              teTarget,
  input  logic              teAck,
  output logic              ireReq,
  output logic              ireTarget,
  input  logic              ireAck,
  output logic              qieReq,
  output logic              qieTarget,
  input  logic              qieAck,
  output logic              dmaRemapEn,
  output logic              intRemapEn,
  output logic              qInvEn,
  output logic              compatBypass,
  output logic [PTR_W-1:0]  rootPtr,
  output logic [PTR_W-1:0]  irtPtr
);
  logic [NUM_LVL-1:0] cmdLvl, lvlCap, lvlTarget, lvlAck, lvlPend, lvlState;
  logic [NUM_OP-1:0]  cmdOp, opCap, opAck, opPend;
  logic [NUM_PTR-1:0] ptrReady;
  logic [NUM_PTR-1:0][PTR_W-1:0] ptrIn, ptrPend, ptrLive;
  logic    compatSel;
  logic    unusedCmdBits;
  strobe_t stb;

  // Field decode
  assign cmdLvl[LV_XLATE] = cmdWrData[POS_XLATE];
  assign cmdLvl[LV_INTR]  = cmdWrData[POS_INTR];
  assign cmdLvl[LV_QINV]  = cmdWrData[POS_QINV];
  assign cmdOp[OP_ROOT]   = cmdWrData[POS_ROOT];
  assign cmdOp[OP_IRT]    = cmdWrData[POS_IRT];
  assign cmdOp[OP_FLUSH]  = cmdWrData[POS_FLUSH];
  assign unusedCmdBits    = ^{cmdWrData[POS_COMPAT-1:0], cmdWrData[POS_ROOT-1:POS_FLUSH+1]};

  // Capability gating
  assign lvlCap[LV_XLATE] = 1'b1;
  assign lvlCap[LV_INTR]  = capIntr;
  assign lvlCap[LV_QINV]  = capQinv;
  assign opCap[OP_ROOT]   = 1'b1;
  assign opCap[OP_IRT]    = capIntr;
  assign opCap[OP_FLUSH]  = capFlush;

  assign lvlAck = {qieAck, ireAck, teAck};
  assign opAck  = {wbfAck, irtpAck, rtpAck};
  assign ptrIn[OP_ROOT] = rootAddrIn;
  assign ptrIn[OP_IRT]  = irtAddrIn;

  remap_gcmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdLvl(cmdLvl), .cmdOp(cmdOp),
    .lvlCap(lvlCap), .opCap(opCap), .compatCap(capIntr), .lvlTarget(lvlTarget),
    .lvlAck(lvlAck), .opAck(opAck), .stb(stb), .lvlPend(lvlPend),
    .lvlState(lvlState), .opPend(opPend), .ptrReady(ptrReady)
  );

  remap_gcmd_dp #(.PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdLvl(cmdLvl),
    .cmdCompat(cmdWrData[POS_COMPAT]), .ptrIn(ptrIn), .lvlTarget(lvlTarget),
    .compatSel(compatSel), .ptrPend(ptrPend), .ptrLive(ptrLive)
  );

  // Status assembly
  always_comb begin
    statusRdData             = '0;
    statusRdData[POS_XLATE]  = lvlState[LV_XLATE];
    statusRdData[POS_INTR]   = lvlState[LV_INTR] & capIntr;
    statusRdData[POS_QINV]   = lvlState[LV_QINV] & capQinv;
    statusRdData[POS_ROOT]   = ptrReady[OP_ROOT];
    statusRdData[POS_IRT]    = ptrReady[OP_IRT] & capIntr;
    statusRdData[POS_FLUSH]  = opPend[OP_FLUSH] & capFlush;
    statusRdData[POS_COMPAT] = compatSel & lvlState[LV_INTR] & capIntr & ~extIntMode;
  end

  assign rtpReq       = opPend[OP_ROOT];
  assign irtpReq      = opPend[OP_IRT];
  assign wbfReq       = opPend[OP_FLUSH];
  assign reqRootPtr   = ptrPend[OP_ROOT];
  assign reqIrtPtr    = ptrPend[OP_IRT];
  assign rootPtr      = ptrLive[OP_ROOT];
  assign irtPtr       = ptrLive[OP_IRT];
  assign teReq        = lvlPend[LV_XLATE];
  assign ireReq       = lvlPend[LV_INTR];
  assign qieReq       = lvlPend[LV_QINV];
  assign teTarget     = lvlTarget[LV_XLATE];
  assign ireTarget    = lvlTarget[LV_INTR];
  assign qieTarget    = lvlTarget[LV_QINV];
  assign dmaRemapEn   = statusRdData[POS_XLATE];
  assign intRemapEn   = statusRdData[POS_INTR];
  assign qInvEn       = statusRdData[POS_QINV];
  assign compatBypass = statusRdData[POS_COMPAT];
endmodule

// File: rtl/remap_gcmd_chk.sv
module remap_gcmd_chk #(
  parameter int PTR_W = 52
) (
  input logic             clk,
  input logic             rstN,
  input logic [31:0]      statusRdData,
  input logic             rtpReq,
  input logic             rtpAck,
  input logic [PTR_W-1:0] reqRootPtr,
  input logic             irtpReq,
  input logic             wbfReq,
  input logic             wbfAck,
  input logic             teReq,
  input logic             teAck,
  input logic             dmaRemapEn,
  input logic             capIntr,
  input logic             capQinv,
  input logic             qieReq,
  input logic             extIntMode
);
  // R2: ready bit stays low while the root load is outstanding
  p_root_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    rtpReq |-> !statusRdData[30]);

  // R8: request and offered pointer hold until acknowledged
  p_root_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rtpReq && !rtpAck) |=> (rtpReq && $stable(reqRootPtr)));

  // R4: flush acknowledge clears busy and request
  p_flush_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wbfReq && wbfAck) |=> (!wbfReq && !statusRdData[27]));

  // R5: translation state moves only on a completed handshake
  p_xlate_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(teReq && teAck) |=> $stable(dmaRemapEn));

  // R10: bypass is visible only with interrupt remapping on and extended mode off
  p_compat_r10: assert property (@(posedge clk) disable iff (!rstN)
    statusRdData[23] |-> (statusRdData[25] && !extIntMode));

  // R9: missing queued invalidation never requests or reports enabled
  p_nocap_qinv_r9: assert property (@(posedge clk) disable iff (!rstN)
    !capQinv |-> (!qieReq && !statusRdData[26]));

  // R3: interrupt table load needs its strap
  p_irt_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    !capIntr |-> !irtpReq);

  // R11: unused status positions read 0
  p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (statusRdData & 32'h307F_FFFF) == 32'h0);
endmodule

bind remap_gcmd_unit remap_gcmd_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .statusRdData(statusRdData), .rtpReq(rtpReq),
  .rtpAck(rtpAck), .reqRootPtr(reqRootPtr), .irtpReq(irtpReq), .wbfReq(wbfReq),
  .wbfAck(wbfAck), .teReq(teReq), .teAck(teAck), .dmaRemapEn(dmaRemapEn),
  .capIntr(capIntr), .capQinv(capQinv), .qieReq(qieReq), .extIntMode(extIntMode)
);

// File: tb/sim_remap_gcmd_unit.sv
`timescale 1ns/1ps
module sim_remap_gcmd_unit;
  localparam int PW = 12;
  localparam logic [31:0] B_COMPAT = 32'h0080_0000;
  localparam logic [31:0] B_IRT    = 32'h0100_0000;
  localparam logic [31:0] B_INTR   = 32'h0200_0000;
  localparam logic [31:0] B_QINV   = 32'h0400_0000;
  localparam logic [31:0] B_FLUSH  = 32'h0800_0000;
  localparam logic [31:0] B_ROOT   = 32'h4000_0000;
  localparam logic [31:0] B_XLATE  = 32'h8000_0000;
  localparam logic [31:0] B_OTHER  = 32'h307F_FFFF;

  logic clk = 1'b0;
  logic rstN;
  logic cmdWrEn;
  logic [31:0] cmdWrData, statusRdData;
  logic capFlush, capIntr, capQinv, extIntMode;
  logic [PW-1:0] rootAddrIn, irtAddrIn, reqRootPtr, reqIrtPtr, rootPtr, irtPtr;
  logic rtpReq, rtpAck, irtpReq, irtpAck, wbfReq, wbfAck;
  logic teReq, teTarget, teAck, ireReq, ireTarget, ireAck, qieReq, qieTarget, qieAck;
  logic dmaRemapEn, intRemapEn, qInvEn, compatBypass;

  int checks = 0;
  int errors = 0;
  bit mRoot, mIrt, mFlush, mXl, mIntr, mQinv, mCompat;

  always #10 clk = ~clk;

  remap_gcmd_unit #(.PTR_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .statusRdData(statusRdData), .capFlush(capFlush), .capIntr(capIntr),
    .capQinv(capQinv), .extIntMode(extIntMode), .rootAddrIn(rootAddrIn),
    .irtAddrIn(irtAddrIn), .rtpReq(rtpReq), .rtpAck(rtpAck), .reqRootPtr(reqRootPtr),
    .irtpReq(irtpReq), .irtpAck(irtpAck), .reqIrtPtr(reqIrtPtr), .wbfReq(wbfReq),
    .wbfAck(wbfAck), .teReq(teReq), .teTarget(teTarget), .teAck(teAck),
    .ireReq(ireReq), .ireTarget(ireTarget), .ireAck(ireAck), .qieReq(qieReq),
    .qieTarget(qieTarget), .qieAck(qieAck), .dmaRemapEn(dmaRemapEn),
    .intRemapEn(intRemapEn), .qInvEn(qInvEn), .compatBypass(compatBypass),
    .rootPtr(rootPtr), .irtPtr(irtPtr)
  );

  function automatic logic [31:0] expStatus();
    logic [31:0] s = '0;
    s[31] = mXl;   s[30] = mRoot; s[27] = mFlush; s[26] = mQinv;
    s[25] = mIntr; s[24] = mIrt;  s[23] = mCompat & mIntr & ~extIntMode;
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkStatus(input string tag);
    check(statusRdData === expStatus(), tag, statusRdData, expStatus());
  endtask

  task automatic wr(input logic [31:0] d);
    cmdWrEn = 1'b1; cmdWrData = d;
    @(negedge clk);
    cmdWrEn = 1'b0; cmdWrData = '0;
  endtask

  task automatic ack(input bit r, input bit i, input bit w, input bit t, input bit ir, input bit q);
    rtpAck = r; irtpAck = i; wbfAck = w; teAck = t; ireAck = ir; qieAck = q;
    @(negedge clk);
    {rtpAck, irtpAck, wbfAck, teAck, ireAck, qieAck} = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0; cmdWrEn = 1'b0; cmdWrData = '0; extIntMode = 1'b0;
    {rtpAck, irtpAck, wbfAck, teAck, ireAck, qieAck} = '0;
    rootAddrIn = '0; irtAddrIn = '0;
    {mRoot, mIrt, mFlush, mXl, mIntr, mQinv, mCompat} = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      logic [PW-1:0] rootA, irtA;
      logic [31:0] base;
      capFlush = c[0]; capIntr = c[1]; capQinv = c[2];
      doReset();
      // R1
      check(statusRdData === 32'h0, "R1 status", statusRdData, 0);
      check({rtpReq, irtpReq, wbfReq, teReq, ireReq, qieReq} === 6'b0, "R1 requests",
            {rtpReq, irtpReq, wbfReq, teReq, ireReq, qieReq}, 0);
      check({dmaRemapEn, intRemapEn, qInvEn, compatBypass, rootPtr, irtPtr} === '0, "R1 enables and pointers",
            {dmaRemapEn, intRemapEn, qInvEn, compatBypass}, 0);

      // R2 root pointer load
      rootA = PW'(12'h100 + c * 7);
      rootAddrIn = rootA;
      wr(B_ROOT);
      check(rtpReq === 1'b1, "R2 request raised", rtpReq, 1);
      checkStatus("R2 ready cleared");
      check(reqRootPtr === rootA, "R2 snapshot", reqRootPtr, rootA);
      // R8 repeat while pending
      rootAddrIn = ~rootA;
      wr(B_ROOT);
      check(rtpReq === 1'b1 && reqRootPtr === rootA, "R8 repeat root ignored", reqRootPtr, rootA);
      ack(1, 0, 0, 0, 0, 0);
      mRoot = 1'b1;
      checkStatus("R2 ready after ack");
      check(rootPtr === rootA && rtpReq === 1'b0, "R2 live pointer", rootPtr, rootA);

      // R12 stray acknowledges
      ack(1, 1, 1, 1, 1, 1);
      checkStatus("R12 stray ack status");
      check(rootPtr === rootA && dmaRemapEn === 1'b0 && irtPtr === '0, "R12 stray ack state", rootPtr, rootA);

      // R3 / R9 interrupt table pointer
      irtA = PW'(12'h0A5 ^ c);
      irtAddrIn = irtA;
      wr(B_IRT);
      check(irtpReq === capIntr, "R3 interrupt table request", irtpReq, capIntr);
      check(reqIrtPtr === (capIntr ? irtA : '0), "R3 interrupt table snapshot", reqIrtPtr, capIntr ? irtA : '0);
      checkStatus("R3 ready cleared");
      ack(0, 1, 0, 0, 0, 0);
      mIrt = capIntr;
      checkStatus("R9 interrupt table status after ack");
      check(irtPtr === (capIntr ? irtA : '0), "R3 interrupt table live", irtPtr, capIntr ? irtA : '0);

      // R4 flush, R8 repeat
      wr(B_FLUSH);
      mFlush = capFlush;
      check(wbfReq === capFlush, "R4 flush request", wbfReq, capFlush);
      checkStatus("R4 flush busy");
      wr(B_FLUSH);
      check(wbfReq === capFlush, "R8 repeat flush", wbfReq, capFlush);
      ack(0, 0, 1, 0, 0, 0);
      mFlush = 1'b0;
      checkStatus("R4 flush done");
      check(wbfReq === 1'b0, "R4 flush request drops", wbfReq, 0);

      // R5 translation enable
      base = B_XLATE;
      wr(base);
      check(teReq === 1'b1 && teTarget === 1'b1, "R5 enable request", {teReq, teTarget}, 2'b11);
      checkStatus("R5 state held until ack");
      ack(0, 0, 0, 1, 0, 0);
      mXl = 1'b1;
      checkStatus("R5 state after ack");
      check(dmaRemapEn === 1'b1 && teReq === 1'b0, "R5 enable output", dmaRemapEn, 1);
      // R7 same value
      wr(base);
      check(teReq === 1'b0, "R7 same value no request", teReq, 0);

      // R6 / R9 / R10 interrupt remap and queued invalidation
      wr(base | B_INTR | B_QINV | B_COMPAT);
      mCompat = capIntr;
      check(ireReq === capIntr && ireTarget === capIntr, "R6 interrupt remap request", ireReq, capIntr);
      check(qieReq === capQinv && qieTarget === capQinv, "R9 queued invalidation gating", qieReq, capQinv);
      checkStatus("R10 bypass hidden before enable");
      ack(0, 0, 0, 0, 1, 1);
      mIntr = capIntr; mQinv = capQinv;
      checkStatus("R6 enables after ack");
      check({intRemapEn, qInvEn} === {capIntr, capQinv}, "R6 enable outputs", {intRemapEn, qInvEn}, {capIntr, capQinv});
      check(compatBypass === capIntr, "R10 bypass visible", compatBypass, capIntr);
      extIntMode = 1'b1;
      #1;
      checkStatus("R10 extended mode hides bypass");
      check(compatBypass === 1'b0, "R10 bypass under extended mode", compatBypass, 0);
      extIntMode = 1'b0;
      @(negedge clk);

      // R11 other bits ignored
      wr(base | B_INTR | B_QINV | B_COMPAT | B_OTHER);
      check({rtpReq, irtpReq, wbfReq, teReq, ireReq, qieReq} === 6'b0, "R11 no requests",
            {rtpReq, irtpReq, wbfReq, teReq, ireReq, qieReq}, 0);
      checkStatus("R11 status unchanged");

      // R10 clear bypass
      wr(base | B_INTR | B_QINV);
      mCompat = 1'b0;
      checkStatus("R10 bypass cleared");
      check(compatBypass === 1'b0, "R10 bypass output cleared", compatBypass, 0);

      // R5 / R6 disable everything
      wr(32'h0);
      check(teReq === 1'b1 && teTarget === 1'b0, "R5 disable request", {teReq, teTarget}, 2'b10);
      check(ireReq === capIntr && qieReq === capQinv, "R6 disable requests", {ireReq, qieReq}, {capIntr, capQinv});
      ack(0, 0, 0, 1, 1, 1);
      mXl = 1'b0; mIntr = 1'b0; mQinv = 1'b0;
      checkStatus("R5 disabled status");
      check(dmaRemapEn === 1'b0, "R5 disabled output", dmaRemapEn, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule